// File: doc/BRIEF.md
# Iterative Multiply Sequencer

This block runs one multiply-class operation at a time for an execute pipeline. Each operation brings an operation code, two 32-bit operands and a 64-bit accumulator input, of which the 32-bit forms use only the low word. The block holds the issue stage off with a stall signal while the operation occupies the shared multiplier for the number of passes its class needs. It then presents the result on a single 32-bit return port in the cycle that class allows. Forms that produce 64 bits return the low word first and the high word in the next cycle.

Flag-setting forms keep the multiplier busy for one extra pass after the value is already out. They report negative and zero flags, taken from the complete result, in their last pass. Once stall drops, a new operation can be accepted while the previous one is still returning its result.

In the requirements, "cycle k" is the k-th clock cycle after the rising edge that accepts the operation. Cycle 1 is the first pass.

Top module: `mulseq_top`

## Requirements
- R1: While rst_n is low and after reset, stall, res_valid, res_hi and flags_valid are 0 and res_data is 0.
- R2: An operation is accepted at a rising edge where start is 1 and stall is 0. Stall is 1 in cycles 1 to P, where P is the pass count of the class, and 0 after that. A start pulse while stall is 1 has no effect on any output.
- R3: Half forms (op[2:0]=0, signed 16x16) and word-by-half forms (op[2:0]=1, signed 32x16, product bits 47..16) without accumulate (op[4]=0) use P=1 and present their result in cycle 2.
- R4: The same two kinds with accumulate (op[4]=1) add acc[31:0], use P=2 and present their result in cycle 2.
- R5: The half-into-long form (op[2:0]=4) adds the signed 16x16 product to the 64-bit acc, uses P=2, and returns the low word in cycle 2 and the high word in cycle 3.
- R6: Word forms (op[2:0]=2, low 32 bits of a times b, plus acc[31:0] when op[4]=1) use P=2 and present their result in cycle 3. With op[5]=1 they use P=4 and still present the value in cycle 3.
- R7: Long forms (op[2:0]=3, 64-bit product, plus the 64-bit acc when op[4]=1) use P=3, returning the low word in cycle 3 and the high word in cycle 4. With op[5]=1 they use P=5, with the same word cycles.
- R8: A 64-bit result is returned as the low word with res_hi=0, followed in the next cycle by the high word with res_hi=1. For 32-bit results res_hi stays 0. res_data is 0 whenever res_valid is 0.
- R9: The returned value equals the exact product plus accumulator for the class, wrapped to the result width.
- R10: For word and long forms with op[5]=1, flags_valid is 1 in cycle P only. flag_n is the result's top bit (bit 31 or 63) and flag_z is 1 when the whole result is zero. op[5] on any other kind is ignored. flag_n and flag_z are 0 whenever flags_valid is 0.
- R11: op[3] selects unsigned operands for long forms only. Kind codes 5 to 7 behave as word forms.
- R12: A new operation can be accepted in the first cycle in which stall is 0, even while the previous operation's result word is on the port. The two operations do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to accept an operation |
| op | input | 6 | [2:0] kind, [3] unsigned, [4] accumulate, [5] set flags |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| acc | input | 64 | Accumulator (low word used by 32-bit forms) |
| stall | output | 1 | Holds the issue stage while passes remain |
| res_valid | output | 1 | Result word is on res_data |
| res_hi | output | 1 | The word on res_data is the high word |
| res_data | output | 32 | Result word |
| flags_valid | output | 1 | Flags are valid this cycle |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
Result return and acceptance can fall in the same cycle. For forms whose result cycle is P+1, the last result word is on the port in the first cycle after stall drops, and that is also the first cycle in which a new start is taken. The bench issues every operation at the earliest cycle its own model allows, so this overlap occurs across all kinds. Each cycle the bench compares the old operation's word, and the new operation's stall and later results, against the model. The bench also pulses start during stall and confirms that no extra stall or result appears.

// File: rtl/mulseq_pkg.sv
package mulseq_pkg;
  localparam int MAX_CYC = 5;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t CNT_ONE = cnt_t'(1);

  // operation kinds carried in op[2:0]
  localparam logic [2:0] MK_HALF  = 3'd0;
  localparam logic [2:0] MK_WHALF = 3'd1;
  localparam logic [2:0] MK_WORD  = 3'd2;
  localparam logic [2:0] MK_LONG  = 3'd3;
  localparam logic [2:0] MK_HLONG = 3'd4;

  typedef struct packed {
    logic       setf;
    logic       accum;
    logic       uns;
    logic [2:0] kind;
  } op_t;

  typedef struct packed {
    cnt_t passes;
    cnt_t ready;
    logic wide;
    logic flags;
  } sched_t;

  // pass count, result cycle and width of each class
  function automatic sched_t op_schedule(logic [2:0] kind, logic accum, logic setf);
    sched_t s;
    s = '0;
    case (kind)
      MK_HALF, MK_WHALF: begin
        s.passes = accum ? cnt_t'(2) : cnt_t'(1);
        s.ready  = cnt_t'(2);
      end
      MK_HLONG: begin
        s.passes = cnt_t'(2);
        s.ready  = cnt_t'(3);
        s.wide   = 1'b1;
      end
      MK_LONG: begin
        s.passes = setf ? cnt_t'(5) : cnt_t'(3);
        s.ready  = cnt_t'(4);
        s.wide   = 1'b1;
        s.flags  = setf;
      end
      default: begin
        s.passes = setf ? cnt_t'(4) : cnt_t'(2);
        s.ready  = cnt_t'(3);
        s.flags  = setf;
      end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/mulseq_ctrl.sv
module mulseq_ctrl
  import mulseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  op_t        op,
  output logic       accept,
  output logic       load_res,
  output logic       stall,
  output logic       res_valid,
  output logic       res_hi,
  output logic       sel_wide,
  output logic       flags_valid
);
  logic   active;
  cnt_t   cnt;
  sched_t sch_q;
  cnt_t   last_cyc;
  logic   hit_ready;
  logic   hit_low;

  assign accept   = start && !stall;
  assign last_cyc = (sch_q.passes > sch_q.ready) ? sch_q.passes : sch_q.ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      stall  <= 1'b0;
      sch_q  <= '0;
    end else if (accept) begin
      active <= 1'b1;
      cnt    <= CNT_ONE;
      stall  <= 1'b1;
      sch_q  <= op_schedule(op.kind, op.accum, op.setf);
    end else if (active) begin
      stall <= (cnt < sch_q.passes);
      if (cnt == last_cyc) active <= 1'b0;
      else                 cnt    <= cnt + CNT_ONE;
    end
  end

  assign load_res    = active && (cnt == CNT_ONE);
  assign hit_ready   = active && (cnt == sch_q.ready);
  assign hit_low     = active && sch_q.wide && (cnt == sch_q.ready - CNT_ONE);
  assign res_valid   = hit_ready || hit_low;
  assign res_hi      = hit_ready && sch_q.wide;
  assign sel_wide    = sch_q.wide;
  assign flags_valid = active && sch_q.flags && (cnt == sch_q.passes);

  // R2
  accept_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> stall);

  // R2
  stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> ($past(cnt) == $past(sch_q.passes)));

  // R10
  flags_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_valid |-> stall);

  // R8
  hi_after_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hi) |-> ($past(res_valid) && !$past(res_hi)));

  // R12
  result_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (stall || $past(stall)));
endmodule

// File: rtl/mulseq_dpath.sv
module mulseq_dpath
  import mulseq_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          load_res,
  input  logic [2:0]    kind,
  input  logic          accum,
  input  logic          uns,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [2*DW-1:0] acc,
  input  logic          res_valid,
  input  logic          res_hi,
  input  logic          sel_wide,
  input  logic          flags_valid,
  output logic [DW-1:0] res_data,
  output logic          flag_n,
  output logic          flag_z
);
  localparam int HW = DW / 2;
  localparam int RW = 2 * DW;

  logic [2:0]    kind_q;
  logic          accum_q;
  logic          uns_q;
  logic [DW-1:0] a_q;
  logic [DW-1:0] b_q;
  logic [RW-1:0] c_q;
  logic [RW-1:0] res_q;
  logic          n_raw;
  logic          z_raw;

  // one signed (DW+1)x(DW+1) array shared by every class
  function automatic logic [RW-1:0] mul_eval(logic [2:0] k, logic ac, logic un,
                                             logic [DW-1:0] a, logic [DW-1:0] b,
                                             logic [RW-1:0] c);
    logic signed [DW:0]   ax;
    logic signed [DW:0]   bx;
    logic signed [RW+1:0] p;
    logic [RW-1:0]        r;
    case (k)
      MK_HALF, MK_HLONG: begin
        ax = {{(DW-HW+1){a[HW-1]}}, a[HW-1:0]};
        bx = {{(DW-HW+1){b[HW-1]}}, b[HW-1:0]};
      end
      MK_WHALF: begin
        ax = {a[DW-1], a};
        bx = {{(DW-HW+1){b[HW-1]}}, b[HW-1:0]};
      end
      MK_LONG: begin
        ax = un ? {1'b0, a} : {a[DW-1], a};
        bx = un ? {1'b0, b} : {b[DW-1], b};
      end
      default: begin
        ax = {a[DW-1], a};
        bx = {b[DW-1], b};
      end
    endcase
    p = ax * bx;
    r = '0;
    case (k)
      MK_WHALF: r[DW-1:0] = p[DW+HW-1:HW] + (ac ? c[DW-1:0] : '0);
      MK_LONG:  r = p[RW-1:0] + (ac ? c : '0);
      MK_HLONG: r = p[RW-1:0] + c;
      default:  r[DW-1:0] = p[DW-1:0] + (ac ? c[DW-1:0] : '0);
    endcase
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= '0;
      accum_q <= 1'b0;
      uns_q   <= 1'b0;
      a_q     <= '0;
      b_q     <= '0;
      c_q     <= '0;
    end else if (capture) begin
      kind_q  <= kind;
      accum_q <= accum;
      uns_q   <= uns;
      a_q     <= opa;
      b_q     <= opb;
      c_q     <= acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        res_q <= '0;
    else if (load_res) res_q <= mul_eval(kind_q, accum_q, uns_q, a_q, b_q, c_q);
  end

  assign n_raw = sel_wide ? res_q[RW-1] : res_q[DW-1];
  assign z_raw = sel_wide ? (res_q == '0) : (res_q[DW-1:0] == '0);

  assign res_data = !res_valid ? '0 : (res_hi ? res_q[RW-1:DW] : res_q[DW-1:0]);
  assign flag_n   = flags_valid && n_raw;
  assign flag_z   = flags_valid && z_raw;

  // R10
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_valid |-> !(flag_n && flag_z));

  // R8
  data_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_data == '0));
endmodule

// File: rtl/mulseq_top.sv
module mulseq_top
  import mulseq_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [5:0]      op,
  input  logic [DW-1:0]   opa,
  input  logic [DW-1:0]   opb,
  input  logic [2*DW-1:0] acc,
  output logic            stall,
  output logic            res_valid,
  output logic            res_hi,
  output logic [DW-1:0]   res_data,
  output logic            flags_valid,
  output logic            flag_n,
  output logic            flag_z
);
  op_t  op_s;
  logic accept;
  logic load_res;
  logic sel_wide;

  assign op_s = op_t'(op);

  mulseq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .op          (op_s),
    .accept      (accept),
    .load_res    (load_res),
    .stall       (stall),
    .res_valid   (res_valid),
    .res_hi      (res_hi),
    .sel_wide    (sel_wide),
    .flags_valid (flags_valid)
  );

  mulseq_dpath #(.DW(DW)) u_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture     (accept),
    .load_res    (load_res),
    .kind        (op_s.kind),
    .accum       (op_s.accum),
    .uns         (op_s.uns),
    .opa         (opa),
    .opb         (opb),
    .acc         (acc),
    .res_valid   (res_valid),
    .res_hi      (res_hi),
    .sel_wide    (sel_wide),
    .flags_valid (flags_valid),
    .res_data    (res_data),
    .flag_n      (flag_n),
    .flag_z      (flag_z)
  );
endmodule

// File: tb/sim_mulseq_top.sv
`timescale 1ns/1ps
module sim_mulseq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  op = '0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic [63:0] acc = '0;
  logic        stall, res_valid, res_hi, flags_valid, flag_n, flag_z;
  logic [31:0] res_data;

  always #2.5 clk = ~clk;

  mulseq_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
    .acc(acc), .stall(stall), .res_valid(res_valid), .res_hi(res_hi),
    .res_data(res_data), .flags_valid(flags_valid), .flag_n(flag_n), .flag_z(flag_z)
  );

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // expected events keyed by absolute cycle number
  bit          e_stall[int];
  bit          e_rv[int];
  bit          e_hi[int];
  logic [31:0] e_dat[int];
  bit          e_fv[int];
  bit          e_n[int];
  bit          e_z[int];
  string       e_tag[int];

  task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: got %0h expected %0h", tag, what, cyc, got, exp);
    end
  endtask

  function automatic logic [63:0] ref_val(logic [5:0] o, logic [31:0] a, logic [31:0] b,
                                          logic [63:0] c);
    longint sa, sb, ha, hb;
    logic [63:0] v;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ha = longint'($signed(a[15:0]));
    hb = longint'($signed(b[15:0]));
    case (o[2:0])
      3'd0: v = ha * hb + (o[4] ? {32'b0, c[31:0]} : 64'd0);
      3'd1: v = ((sa * hb) >>> 16) + (o[4] ? {32'b0, c[31:0]} : 64'd0);
      3'd3: begin
        v = o[3] ? ({32'b0, a} * {32'b0, b}) : sa * sb;
        if (o[4]) v = v + c;
      end
      3'd4: v = ha * hb + c;
      default: v = sa * sb + (o[4] ? {32'b0, c[31:0]} : 64'd0);
    endcase
    if (o[2:0] != 3'd3 && o[2:0] != 3'd4) v = {32'b0, v[31:0]};
    return v;
  endfunction

  function automatic string kind_tag(logic [5:0] o);
    case (o[2:0])
      3'd0, 3'd1: return o[4] ? "R4" : "R3";
      3'd3:       return "R7";
      3'd4:       return "R5";
      3'd2:       return "R6";
      default:    return "R11";
    endcase
  endfunction

  // drive at a falling edge; model predicts acceptance from its own stall
  task automatic issue(logic [5:0] o, logic [31:0] a, logic [31:0] b, logic [63:0] c,
                       string tag, bit retry);
    bit done;
    done = 1'b0;
    while (!done) begin
      int n, p, r;
      bit w, f;
      logic [63:0] v;
      start = 1'b1; op = o; opa = a; opb = b; acc = c;
      n = cyc;
      if (!e_stall.exists(n)) begin
        case (o[2:0])
          3'd0, 3'd1: begin p = o[4] ? 2 : 1; r = 2; w = 0; f = 0; end
          3'd4:       begin p = 2; r = 3; w = 1; f = 0; end
          3'd3:       begin p = o[5] ? 5 : 3; r = 4; w = 1; f = o[5]; end
          default:    begin p = o[5] ? 4 : 2; r = 3; w = 0; f = o[5]; end
        endcase
        v = ref_val(o, a, b, c);
        for (int k = 1; k <= p; k++) e_stall[n + k] = 1'b1;
        if (w) begin
          e_rv[n + r - 1] = 1'b1; e_hi[n + r - 1] = 1'b0; e_dat[n + r - 1] = v[31:0];
          e_tag[n + r - 1] = tag;
          e_rv[n + r] = 1'b1; e_hi[n + r] = 1'b1; e_dat[n + r] = v[63:32];
        end else begin
          e_rv[n + r] = 1'b1; e_dat[n + r] = v[31:0];
        end
        e_tag[n + r] = tag;
        if (f) begin
          e_fv[n + p] = 1'b1;
          e_n[n + p] = w ? v[63] : v[31];
          e_z[n + p] = w ? (v == 64'd0) : (v[31:0] == 32'd0);
        end
        done = 1'b1;
      end
      @(negedge clk);
      if (!retry) done = 1'b1;
    end
    start = 1'b0;
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1", "stall", {63'b0, stall}, 64'd0);
      chk("R1", "res_valid", {63'b0, res_valid}, 64'd0);
      chk("R1", "flags_valid", {63'b0, flags_valid}, 64'd0);
      chk("R1", "res_data", {32'b0, res_data}, 64'd0);
    end else begin
      chk("R2", "stall", {63'b0, stall}, {63'b0, e_stall.exists(cyc)});
      chk(e_tag.exists(cyc) ? e_tag[cyc] : "R2", "res_valid", {63'b0, res_valid},
          {63'b0, e_rv.exists(cyc)});
      chk("R8", "res_hi", {63'b0, res_hi}, {63'b0, e_hi.exists(cyc) ? e_hi[cyc] : 1'b0});
      chk("R9", "res_data", {32'b0, res_data}, {32'b0, e_dat.exists(cyc) ? e_dat[cyc] : 32'd0});
      chk("R10", "flags_valid", {63'b0, flags_valid}, {63'b0, e_fv.exists(cyc)});
      chk("R10", "flag_n", {63'b0, flag_n}, {63'b0, e_n.exists(cyc) ? e_n[cyc] : 1'b0});
      chk("R10", "flag_z", {63'b0, flag_z}, {63'b0, e_z.exists(cyc) ? e_z[cyc] : 1'b0});
    end
  end

  initial begin
    #(5.0 * 20000);
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit [5:0] rop;
    repeat (4) @(negedge clk);           // R1 reset state checked meanwhile
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // op = {setf, accum, uns, kind}
    issue(6'b000000, 32'h0000FFFF, 32'h00007FFF, 64'd0, "R3", 1);
    issue(6'b010000, 32'h00008000, 32'h00008000, 64'h0000_0000_0000_0005, "R4", 1);
    issue(6'b000001, 32'h80000000, 32'h00008000, 64'd0, "R3", 1);
    issue(6'b010001, 32'h12345678, 32'hFFFF9ABC, 64'h0000_0000_1111_1111, "R4", 1);
    issue(6'b010100, 32'h00008000, 32'h00007FFF, 64'h0000_0001_0000_0000, "R5", 1);
    issue(6'b000010, 32'hDEADBEEF, 32'h00000007, 64'd0, "R6", 1);
    issue(6'b010010, 32'h00010001, 32'h00010001, 64'hFFFF_FFFF_FFFF_FFFF, "R6", 1);
    issue(6'b100010, 32'h00000000, 32'h12345678, 64'd0, "R6", 1);        // Z set
    issue(6'b110010, 32'hFFFFFFFF, 32'h00000003, 64'h0000_0000_0000_0001, "R6", 1); // N set
    issue(6'b001011, 32'hFFFFFFFF, 32'hFFFFFFFF, 64'd0, "R7", 1);
    issue(6'b011011, 32'hFFFFFFFF, 32'hFFFFFFFF, 64'h0000_0000_0000_0001, "R7", 1);
    issue(6'b000011, 32'hFFFFFFFF, 32'hFFFFFFFF, 64'd0, "R11", 1);       // signed long
    issue(6'b010011, 32'h80000000, 32'h7FFFFFFF, 64'h8000_0000_0000_0000, "R7", 1);
    issue(6'b100011, 32'h80000000, 32'h00000002, 64'd0, "R7", 1);        // N set
    issue(6'b111011, 32'h00000000, 32'h00000000, 64'd0, "R7", 1);        // Z set
    issue(6'b100000, 32'h00000003, 32'h00000004, 64'd0, "R10", 1);       // setf ignored
    issue(6'b100100, 32'h0000FFFF, 32'h00000002, 64'd0, "R10", 1);       // setf ignored
    issue(6'b001010, 32'hFFFFFFFF, 32'h00000002, 64'd0, "R11", 1);       // uns ignored
    issue(6'b000101, 32'h00000011, 32'h00000013, 64'd0, "R11", 1);       // kind 5
    issue(6'b110111, 32'h00000000, 32'h00000009, 64'd0, "R11", 1);       // kind 7 flags
    // R2: a start during stall is ignored
    issue(6'b100011, 32'h00000123, 32'h00000456, 64'd0, "R7", 1);
    issue(6'b000000, 32'h00000001, 32'h00000001, 64'd0, "R2", 0);
    issue(6'b000000, 32'h00000002, 32'h00000002, 64'd0, "R2", 0);
    // R12: back-to-back long and half-into-long forms
    issue(6'b000011, 32'h7FFFFFFF, 32'h7FFFFFFF, 64'd0, "R12", 1);
    issue(6'b010100, 32'h0000FFFF, 32'h0000FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R12", 1);
    issue(6'b000000, 32'h00007FFF, 32'h00007FFF, 64'd0, "R12", 1);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 60; i++) begin
      rop = 6'($urandom_range(0, 63));
      issue(rop, $urandom, $urandom, {$urandom, $urandom}, kind_tag(rop), 1);
      if ((i % 7) == 3) repeat (2) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule